// File: doc/BRIEF.md
# Byte-to-Word Shared RAM Bridge

This block lets an 8-bit processor bus reach a working RAM of 32-bit words that a compute engine also uses. To the processor, the RAM is a 512-byte window. Because each RAM word spans four byte addresses, two registers sit between the bus and the array. A read latch captures a whole word when its lowest byte is read, so that the later byte reads see one consistent snapshot. A write staging register collects the lower three bytes, and the write of the top byte stores all 32 bits in a single RAM write.

The processor bus holds a read or write strobe high until a one-cycle ready pulse appears. Each access costs a number of wait states, and that number follows a speed setting which tracks the processor clock. A faster processor clock needs more wait states. The compute engine has its own word port, and that port always wins the RAM. A bus access that needs the array stalls while the engine is using it.

Top module: `shared_ram_byte_bridge`

## Requirements
- R1: The bridge answers only bus addresses 0x1000 to 0x11FF. A strobe outside that range never raises ready and changes neither the RAM nor the staging register.
- R2: Within the window, address bits [1:0] pick the byte lane, with lane 0 as word bits [7:0] (little-endian). Address bits [8:2] pick one of the 128 words.
- R3: The wait-state count is the number of strobe cycles before ready rises. With no contention it is 5 for speed setting 0, 2 for setting 1, and 1 for settings 2 and 3. Ready is high for exactly one cycle.
- R4: A read of lane 0 loads the full RAM word into the read latch and returns bits [7:0].
- R5: A read of lane 1, 2 or 3 of the word held in the read latch returns the latched byte, even if the RAM word changed after it was latched.
- R6: A read of lane 1, 2 or 3 of any other word, or before any lane 0 read, returns the current RAM byte and leaves the latch unchanged.
- R7: A write to lane 0, 1 or 2 only updates the staging register and leaves the RAM unchanged. A write to lane 3 stores {lane 3 data, staged lanes 2..0} into the word in one RAM write.
- R8: The engine port writes at the clock edge when its request and write-enable are both high. An engine read returns the word one cycle later, and the engine read data holds its value while no engine read is requested.
- R9: The engine has priority. A bus access that needs the array (a lane 0 read, a non-latched lane read, or a lane 3 write) cannot complete while the engine requests. With the engine busy for K cycles from the strobe's first cycle, the wait count is max(W, K+1). Latched reads and staging writes still take exactly W.
- R10: After reset, ready and the bus read data are 0, the engine read data is 0, the read latch holds nothing valid, and the staging register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spd_sel | input | 2 | Processor speed setting; picks the wait-state count |
| bus_addr | input | 16 | Byte address on the processor bus |
| bus_wdata | input | 8 | Byte to write |
| bus_rd | input | 1 | Read strobe, held until ready |
| bus_wr | input | 1 | Write strobe, held until ready |
| bus_rdata | output | 8 | Byte read, valid while ready is high |
| bus_ready | output | 1 | One-cycle completion pulse |
| eng_req | input | 1 | Engine RAM request |
| eng_we | input | 1 | Engine write enable |
| eng_addr | input | 7 | Engine word address |
| eng_wdata | input | 32 | Engine write word |
| eng_rdata | output | 32 | Engine read word, one cycle after request |

## Verification
The bench targets three ways this block can go wrong.

- **Torn snapshot.** The engine overwrites a word between its lane 0 read and its upper-lane reads. A design that reads the RAM directly would return bytes from the new value instead of the snapshot.
- **Lost or wrong wait states.** Every speed setting is swept, and the engine is held on the RAM for a run of cycle counts. An arbiter that ignored priority, or that counted its wait from the wrong edge, would show a wait count off by one or more from max(W, K+1).
- **Unintended RAM writes.** The bench checks that lane 0-2 writes, writes that arrive through mirror addresses outside the window, and stale staging contents after reset never reach the RAM. A design with a wrong decode or an eager commit would leave a changed word behind for the engine port to read.

// File: rtl/srb_pkg.sv
package srb_pkg;
   // speed settings; the processor clock falls by roughly 4x and 8x for the lower ones
   typedef enum logic [1:0] {
      SPD_FULL    = 2'd0,
      SPD_QUARTER = 2'd1,
      SPD_EIGHTH  = 2'd2,
      SPD_LOWEST  = 2'd3
   } speed_e;

   // kind of byte access the bus is presenting
   typedef enum logic [2:0] {
      ACC_LATCH_RD  = 3'd0,
      ACC_HOLD_RD   = 3'd1,
      ACC_DIRECT_RD = 3'd2,
      ACC_STAGE_WR  = 3'd3,
      ACC_COMMIT_WR = 3'd4
   } access_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/srb_wait_sel.sv
module srb_wait_sel
   import srb_pkg::*;
#(
   parameter int unsigned WAIT_FULL    = 5,
   parameter int unsigned WAIT_QUARTER = 2,
   parameter int unsigned WAIT_EIGHTH  = 1,
   parameter int unsigned CNT_W        = 3
) (
   input  speed_e           spd,
   output logic [CNT_W-1:0] wait_cnt
);
   // elaboration-time checks: every setting needs at least one wait
   if (WAIT_FULL < 1 || WAIT_QUARTER < 1 || WAIT_EIGHTH < 1) begin : g_bad_wait
      $error("srb_wait_sel: wait counts must be at least 1");
   end
   if ((1 << CNT_W) <= max3(WAIT_FULL, WAIT_QUARTER, WAIT_EIGHTH)) begin : g_bad_cnt
      $error("srb_wait_sel: CNT_W too narrow");
   end

   always_comb begin
      unique case (spd)
         SPD_FULL:    wait_cnt = CNT_W'(WAIT_FULL);
         SPD_QUARTER: wait_cnt = CNT_W'(WAIT_QUARTER);
         default:     wait_cnt = CNT_W'(WAIT_EIGHTH);
      endcase
   end
endmodule

// File: rtl/srb_hold_regs.sv
module srb_hold_regs #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned WORD_AW = 7,
   localparam int unsigned BYTES  = DATA_W / 8,
   localparam int unsigned LANE_W = $clog2(BYTES),
   localparam int unsigned STG_W  = DATA_W - 8
) (
   input  logic               clk,
   input  logic               rst_n,
   // read latch
   input  logic               latch_en,
   input  logic [DATA_W-1:0]  latch_word,
   input  logic [WORD_AW-1:0] latch_idx,
   output logic [DATA_W-1:0]  latch_data,
   output logic [WORD_AW-1:0] latch_tag,
   output logic               latch_valid,
   // write staging
   input  logic               stage_en,
   input  logic [LANE_W-1:0]  stage_lane,
   input  logic [7:0]         stage_byte,
   output logic [STG_W-1:0]   stage_data
);
   logic [7:0] stage_b [BYTES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_data  <= '0;
         latch_tag   <= '0;
         latch_valid <= 1'b0;
      end else if (latch_en) begin
         latch_data  <= latch_word;
         latch_tag   <= latch_idx;
         latch_valid <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < BYTES - 1; i++) stage_b[i] <= '0;
      end else if (stage_en) begin
         for (int i = 0; i < BYTES - 1; i++) begin
            if (stage_lane == LANE_W'(i)) stage_b[i] <= stage_byte;
         end
      end
   end

   for (genvar g = 0; g < BYTES - 1; g++) begin : g_stage_out
      assign stage_data[g*8 +: 8] = stage_b[g];
   end
endmodule

// File: rtl/srb_word_ram.sv
module srb_word_ram #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 128,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   // engine port, always wins
   input  logic              eng_req,
   input  logic              eng_we,
   input  logic [AW-1:0]     eng_addr,
   input  logic [DATA_W-1:0] eng_wdata,
   output logic [DATA_W-1:0] eng_rdata,
   // bridge port
   output logic              br_grant,
   input  logic              br_we,
   input  logic [AW-1:0]     br_addr,
   input  logic [DATA_W-1:0] br_wdata,
   output logic [DATA_W-1:0] br_rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   assign br_grant = !eng_req;
   assign br_rdata = mem[br_addr];

   always_ff @(posedge clk) begin
      if (eng_req && eng_we)
         mem[eng_addr] <= eng_wdata;
      else if (br_we && br_grant)
         mem[br_addr] <= br_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         eng_rdata <= '0;
      else if (eng_req && !eng_we)
         eng_rdata <= mem[eng_addr];
   end
endmodule

// File: rtl/shared_ram_byte_bridge.sv
module shared_ram_byte_bridge
   import srb_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned DEPTH        = 128,
   parameter int unsigned ADDR_W       = 16,
   parameter logic [15:0] BASE_ADDR    = 16'h1000,
   parameter int unsigned WAIT_FULL    = 5,
   parameter int unsigned WAIT_QUARTER = 2,
   parameter int unsigned WAIT_EIGHTH  = 1,
   localparam int unsigned BYTES   = DATA_W / 8,
   localparam int unsigned LANE_W  = $clog2(BYTES),
   localparam int unsigned WORD_AW = $clog2(DEPTH),
   localparam int unsigned WIN_AW  = WORD_AW + LANE_W,
   localparam int unsigned CNT_W   = $clog2(max3(WAIT_FULL, WAIT_QUARTER, WAIT_EIGHTH) + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         spd_sel,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [7:0]         bus_wdata,
   input  logic               bus_rd,
   input  logic               bus_wr,
   output logic [7:0]         bus_rdata,
   output logic               bus_ready,
   input  logic               eng_req,
   input  logic               eng_we,
   input  logic [WORD_AW-1:0] eng_addr,
   input  logic [DATA_W-1:0]  eng_wdata,
   output logic [DATA_W-1:0]  eng_rdata
);
   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || BYTES < 2) begin : g_bad_width
      $error("shared_ram_byte_bridge: DATA_W must be a multiple of 8, at least 16");
   end
   if ((1 << WORD_AW) != DEPTH) begin : g_bad_depth
      $error("shared_ram_byte_bridge: DEPTH must be a power of two");
   end
   if (WIN_AW >= ADDR_W) begin : g_bad_win
      $error("shared_ram_byte_bridge: window does not fit the bus address");
   end
   if ((BASE_ADDR & 16'((1 << WIN_AW) - 1)) != 16'h0) begin : g_bad_base
      $error("shared_ram_byte_bridge: BASE_ADDR must be window-aligned");
   end

   // address decode
   logic               in_win;
   logic               strobe;
   logic [LANE_W-1:0]  lane;
   logic [WORD_AW-1:0] widx;

   assign in_win = (bus_addr[ADDR_W-1:WIN_AW] == BASE_ADDR[ADDR_W-1:WIN_AW]);
   assign strobe = (bus_rd || bus_wr) && in_win;
   assign lane   = bus_addr[LANE_W-1:0];
   assign widx   = bus_addr[WIN_AW-1:LANE_W];

   // wait count for the current speed setting
   logic [CNT_W-1:0] wait_cnt;

   srb_wait_sel #(
      .WAIT_FULL   (WAIT_FULL),
      .WAIT_QUARTER(WAIT_QUARTER),
      .WAIT_EIGHTH (WAIT_EIGHTH),
      .CNT_W       (CNT_W)
   ) u_wait (
      .spd     (speed_e'(spd_sel)),
      .wait_cnt(wait_cnt)
   );

   // holding registers
   logic [DATA_W-1:0]  latch_data;
   logic [WORD_AW-1:0] latch_tag;
   logic               latch_valid;
   logic [DATA_W-9:0]  stage_data;
   logic               latch_en;
   logic               stage_en;
   logic [DATA_W-1:0]  ram_rdata;

   srb_hold_regs #(
      .DATA_W (DATA_W),
      .WORD_AW(WORD_AW)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .latch_en   (latch_en),
      .latch_word (ram_rdata),
      .latch_idx  (widx),
      .latch_data (latch_data),
      .latch_tag  (latch_tag),
      .latch_valid(latch_valid),
      .stage_en   (stage_en),
      .stage_lane (lane),
      .stage_byte (bus_wdata),
      .stage_data (stage_data)
   );

   // shared array
   logic ram_grant;
   logic ram_we;

   srb_word_ram #(
      .DATA_W(DATA_W),
      .DEPTH (DEPTH)
   ) u_ram (
      .clk      (clk),
      .rst_n    (rst_n),
      .eng_req  (eng_req),
      .eng_we   (eng_we),
      .eng_addr (eng_addr),
      .eng_wdata(eng_wdata),
      .eng_rdata(eng_rdata),
      .br_grant (ram_grant),
      .br_we    (ram_we),
      .br_addr  (widx),
      .br_wdata ({bus_wdata, stage_data}),
      .br_rdata (ram_rdata)
   );

   // classify the access
   access_e kind;
   logic    needs_ram;

   always_comb begin
      if (bus_wr)
         kind = (lane == LANE_W'(BYTES - 1)) ? ACC_COMMIT_WR : ACC_STAGE_WR;
      else if (lane == '0)
         kind = ACC_LATCH_RD;
      else if (latch_valid && latch_tag == widx)
         kind = ACC_HOLD_RD;
      else
         kind = ACC_DIRECT_RD;
   end

   assign needs_ram = (kind == ACC_LATCH_RD) || (kind == ACC_DIRECT_RD) ||
                      (kind == ACC_COMMIT_WR);

   // wait-state sequencing
   logic             busy_q;
   logic             ready_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_now;
   logic             finish;
   logic [7:0]       rd_byte;
   logic [7:0]       rdata_q;

   assign cnt_now = busy_q ? cnt_q : (wait_cnt - CNT_W'(1));
   assign finish  = strobe && !ready_q && (cnt_now == '0) && (!needs_ram || ram_grant);

   assign latch_en = finish && (kind == ACC_LATCH_RD);
   assign stage_en = finish && (kind == ACC_STAGE_WR);
   assign ram_we   = finish && (kind == ACC_COMMIT_WR);

   always_comb begin
      unique case (kind)
         ACC_HOLD_RD:   rd_byte = latch_data[lane*8 +: 8];
         ACC_LATCH_RD,
         ACC_DIRECT_RD: rd_byte = ram_rdata[lane*8 +: 8];
         default:       rd_byte = rdata_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         ready_q <= 1'b0;
         cnt_q   <= '0;
         rdata_q <= '0;
      end else if (ready_q) begin
         ready_q <= 1'b0;
         busy_q  <= 1'b0;
      end else if (strobe) begin
         if (finish) begin
            ready_q <= 1'b1;
            busy_q  <= 1'b0;
            rdata_q <= rd_byte;
         end else begin
            busy_q <= 1'b1;
            cnt_q  <= (cnt_now == '0) ? '0 : cnt_now - CNT_W'(1);
         end
      end else begin
         busy_q <= 1'b0;
      end
   end

   assign bus_ready = ready_q;
   assign bus_rdata = rdata_q;
endmodule

// File: rtl/srb_checker.sv
module srb_checker #(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DEPTH        = 128,
   parameter logic [15:0] BASE_ADDR    = 16'h1000,
   parameter int unsigned WAIT_FULL    = 5,
   parameter int unsigned WAIT_QUARTER = 2,
   parameter int unsigned WAIT_EIGHTH  = 1,
   localparam int unsigned BYTES  = DATA_W / 8,
   localparam int unsigned LANE_W = $clog2(BYTES),
   localparam int unsigned WIN_AW = $clog2(DEPTH) + LANE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        spd_sel,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic              bus_ready,
   input logic              eng_req,
   input logic              eng_we,
   input logic [DATA_W-1:0] eng_rdata
);
   logic       acc;
   logic       ram_need;
   logic [7:0] low_cnt;
   logic [7:0] want_q;

   assign acc = (bus_rd || bus_wr) &&
                (bus_addr[ADDR_W-1:WIN_AW] == BASE_ADDR[ADDR_W-1:WIN_AW]);
   assign ram_need = bus_wr ? (bus_addr[LANE_W-1:0] == LANE_W'(BYTES - 1))
                            : (bus_rd && bus_addr[LANE_W-1:0] == '0);

   // count strobe cycles before ready; remember the wait due at the start
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt <= '0;
         want_q  <= '0;
      end else begin
         if (acc && !bus_ready) begin
            if (low_cnt != 8'hFF) low_cnt <= low_cnt + 8'd1;
            if (low_cnt == '0)
               want_q <= (spd_sel == 2'd0) ? 8'(WAIT_FULL) :
                         (spd_sel == 2'd1) ? 8'(WAIT_QUARTER) : 8'(WAIT_EIGHTH);
         end else begin
            low_cnt <= '0;
         end
      end
   end

   AST_READY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |-> acc); // R1
   AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready); // R3
   AST_WAIT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |-> (low_cnt >= want_q)); // R3
   AST_ENG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ready && ram_need) |-> !$past(eng_req)); // R9
   AST_ENG_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_req && !eng_we) |=> $stable(eng_rdata)); // R8
endmodule

bind shared_ram_byte_bridge srb_checker #(
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .DEPTH       (DEPTH),
   .BASE_ADDR   (BASE_ADDR),
   .WAIT_FULL   (WAIT_FULL),
   .WAIT_QUARTER(WAIT_QUARTER),
   .WAIT_EIGHTH (WAIT_EIGHTH)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .spd_sel  (spd_sel),
   .bus_addr (bus_addr),
   .bus_rd   (bus_rd),
   .bus_wr   (bus_wr),
   .bus_ready(bus_ready),
   .eng_req  (eng_req),
   .eng_we   (eng_we),
   .eng_rdata(eng_rdata)
);

// File: tb/shared_ram_byte_bridge_bench.sv
module shared_ram_byte_bridge_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  spd_sel = 2'd0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_rdata;
   logic        bus_ready;
   logic        eng_req = 1'b0;
   logic        eng_we = 1'b0;
   logic [6:0]  eng_addr = '0;
   logic [31:0] eng_wdata = '0;
   logic [31:0] eng_rdata;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shared_ram_byte_bridge u_shared_ram_byte_bridge (
      .clk(clk), .rst_n(rst_n), .spd_sel(spd_sel),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
      .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
   );

   function automatic logic [31:0] pat(input int i);
      return {8'(i * 7 + 1), 8'(i ^ 8'h3C), 8'(255 - i), 8'(i * 3)};
   endfunction

   function automatic int exp_wait(input int s);
      return (s == 0) ? 5 : (s == 1) ? 2 : 1;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_access(input logic [15:0] a, input logic wr, input logic [7:0] wd,
                             output logic [7:0] rd, output int waits);
      @(negedge clk);
      bus_addr = a; bus_wr = wr; bus_rd = !wr; bus_wdata = wd; waits = 0;
      while (!bus_ready && waits < 1000) begin
         waits++;
         @(negedge clk);
      end
      rd = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic eng_write(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      eng_req = 1'b1; eng_we = 1'b1; eng_addr = a; eng_wdata = d;
      @(negedge clk);
      eng_req = 1'b0; eng_we = 1'b0;
   endtask

   task automatic eng_read(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      eng_req = 1'b1; eng_we = 1'b0; eng_addr = a;
      @(negedge clk);
      d = eng_rdata;
      eng_req = 1'b0;
   endtask

   task automatic eng_hold(input int k);
      @(negedge clk);
      eng_req = 1'b1; eng_we = 1'b0; eng_addr = 7'd50;
      repeat (k) @(negedge clk);
      eng_req = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0]  rb;
      logic [31:0] w;
      int          wt;
      int          readies;

      repeat (5) @(negedge clk);
      // R10 reset state
      chk("R10 ready", 32'(bus_ready), 0);
      chk("R10 rdata", 32'(bus_rdata), 0);
      chk("R10 eng_rdata", eng_rdata, 0);
      rst_n = 1'b1;

      // R6 with no latch yet: lane 1 read returns RAM byte
      eng_write(7'd0, 32'h11223344);
      bus_access(16'h1001, 1'b0, 8'h0, rb, wt);
      chk("R6 unlatched read", 32'(rb), 32'h33);
      chk("R3 wait at speed 0", 32'(wt), 5);

      // R10 staging cleared at reset: commit alone writes zero low bytes
      bus_access(16'h1007, 1'b1, 8'hAB, rb, wt);
      eng_read(7'd1, w);
      chk("R10 staging zero / R7 commit", w, 32'hAB000000);

      // R3 sweep over speed settings
      for (int s = 0; s < 4; s++) begin
         spd_sel = 2'(s);
         bus_access(16'h1000, 1'b0, 8'h0, rb, wt);
         chk($sformatf("R3 read wait sel%0d", s), 32'(wt), 32'(exp_wait(s)));
         bus_access(16'h1004, 1'b1, 8'h5A, rb, wt);
         chk($sformatf("R3 write wait sel%0d", s), 32'(wt), 32'(exp_wait(s)));
      end

      // R7 and R2: fill every word through the byte bus
      spd_sel = 2'd2;
      for (int i = 0; i < 128; i++) begin
         for (int b = 0; b < 4; b++) begin
            if (i == 1 && b == 3) begin
               eng_read(7'd1, w);
               chk("R7 no commit before lane 3", w, 32'hAB000000);
            end
            bus_access(16'h1000 + 16'(i * 4 + b), 1'b1, pat(i)[b*8 +: 8], rb, wt);
         end
      end
      for (int i = 0; i < 128; i++) begin
         eng_read(7'(i), w);
         chk($sformatf("R7 R2 word %0d", i), w, pat(i));
      end

      // R4 R5 R2: read every byte back
      for (int i = 0; i < 128; i++) begin
         for (int b = 0; b < 4; b++) begin
            bus_access(16'h1000 + 16'(i * 4 + b), 1'b0, 8'h0, rb, wt);
            chk($sformatf("R4 R5 word %0d lane %0d", i, b), 32'(rb), 32'(pat(i)[b*8 +: 8]));
         end
      end

      // R5 snapshot survives an engine overwrite
      bus_access(16'h1028, 1'b0, 8'h0, rb, wt);
      chk("R4 lane0 word10", 32'(rb), 32'(pat(10)[7:0]));
      eng_write(7'd10, 32'hDEADBEEF);
      for (int b = 1; b < 4; b++) begin
         bus_access(16'h1028 + 16'(b), 1'b0, 8'h0, rb, wt);
         chk($sformatf("R5 latched lane %0d", b), 32'(rb), 32'(pat(10)[b*8 +: 8]));
      end
      // R6 other word reads RAM, latch kept
      bus_access(16'h102D, 1'b0, 8'h0, rb, wt);
      chk("R6 other word", 32'(rb), 32'(pat(11)[15:8]));
      bus_access(16'h102A, 1'b0, 8'h0, rb, wt);
      chk("R6 latch unchanged", 32'(rb), 32'(pat(10)[23:16]));
      bus_access(16'h1028, 1'b0, 8'h0, rb, wt);
      chk("R4 relatch new word", 32'(rb), 32'hEF);

      // R9 engine priority
      for (int k = 1; k <= 4; k++) begin
         fork
            bus_access(16'h1050, 1'b0, 8'h0, rb, wt);
            eng_hold(k);
         join
         chk($sformatf("R9 stall k=%0d", k), 32'(wt), 32'(k + 1));
         chk("R9 stalled read data", 32'(rb), 32'(pat(20)[7:0]));
      end
      fork
         bus_access(16'h1051, 1'b0, 8'h0, rb, wt);
         eng_hold(3);
      join
      chk("R9 latched read ignores engine", 32'(wt), 1);
      spd_sel = 2'd0;
      fork
         bus_access(16'h1050, 1'b0, 8'h0, rb, wt);
         eng_hold(2);
      join
      chk("R9 wait dominates", 32'(wt), 5);
      fork
         bus_access(16'h1050, 1'b0, 8'h0, rb, wt);
         eng_hold(7);
      join
      chk("R9 engine dominates", 32'(wt), 8);
      spd_sel = 2'd2;
      fork
         bus_access(16'h1057, 1'b1, 8'h77, rb, wt);
         eng_hold(3);
      join
      chk("R9 commit stall", 32'(wt), 4);
      eng_read(7'd21, w);
      chk("R9 R7 commit data", w, {8'h77, pat(127)[23:0]});

      // R1 out-of-window strobes are ignored
      readies = 0;
      @(negedge clk);
      bus_addr = 16'h1203; bus_wr = 1'b1; bus_wdata = 8'hC3;
      repeat (10) begin
         @(negedge clk);
         if (bus_ready) readies++;
      end
      bus_addr = 16'h0FFC; bus_wr = 1'b0; bus_rd = 1'b1;
      repeat (10) begin
         @(negedge clk);
         if (bus_ready) readies++;
      end
      bus_rd = 1'b0;
      chk("R1 no ready outside", 32'(readies), 0);
      eng_read(7'd0, w);
      chk("R1 RAM unchanged", w, pat(0));
      bus_access(16'h1013, 1'b1, 8'h99, rb, wt);
      eng_read(7'd4, w);
      chk("R1 staging unchanged", w, {8'h99, pat(127)[23:0]});

      // R8 engine port timing and hold
      eng_write(7'd60, 32'hCAFEF00D);
      eng_read(7'd60, w);
      chk("R8 read after write", w, 32'hCAFEF00D);
      repeat (3) @(negedge clk);
      chk("R8 rdata held", eng_rdata, 32'hCAFEF00D);

      finish_run();
   end
endmodule